// File: doc/BRIEF.md
# Memory-Resident Case Dispatch Engine

This engine resolves a multi-way branch. It is given a table base address, a 16-bit switch value and a table mode. It then walks a jump table held in word-addressed memory and returns one of two results. The first is a jump target, with the hit flag set. The second is the continuation address just past the table, with the hit flag clear. Memory is read through a simple read port: a request made in one cycle returns its data in the next cycle. Only one command is handled at a time.

There are two table kinds. A dense table starts with a header of two words, the highest case value and then the entry count. The entries follow in descending case order, so the first entry belongs to the highest case. A sparse table starts with a pair count. Key and offset pairs follow, and they are searched in order. In both kinds, an entry holds an offset relative to its own address. The target is that address plus the stored word, modulo 2^16.

The controller is a single state machine with these states:

- `ST_IDLE` accepts a command and moves to `ST_HEAD`.
- `ST_HEAD` reads the first header word, then moves to `ST_DNUM` for a dense table or to `ST_SINIT` for a sparse table.
- `ST_DNUM` reads the entry count and latches the difference between the highest case and the switch value. It moves to `ST_DCHK`.
- `ST_DCHK` moves to `ST_OFFRD` when the value is in range, and to `ST_DONE` when it is not.
- `ST_SINIT` moves to `ST_DONE` when the pair count is zero, and to `ST_SKEY` otherwise.
- `ST_SKEY` reads a key and moves to `ST_SCMP`.
- `ST_SCMP` moves to `ST_OFFRD` when the key matches. On a mismatch it moves to `ST_DONE` if that was the last pair, and back to `ST_SKEY` if it was not.
- `ST_OFFRD` reads the offset word and moves to `ST_TGT`.
- `ST_TGT` forms the target and moves to `ST_DONE`.
- `ST_DONE` pulses `done` and returns to `ST_IDLE`.

Top module: `case_dispatch`

## Requirements
- R1: With `cmd_mode`=0 (dense), the word at base is the highest case L, base+1 holds the count N, and the entry for switch value v is at E=base+2+(L-v). On a hit, `res_addr` is E plus the word stored at E, modulo 2^16.
- R2: A dense lookup hits only if v is not greater than L (unsigned) and N is strictly greater than L-v. Every other case misses, including N=0.
- R3: On a dense miss, `res_hit` is 0, `res_addr` is base+2+N, and `res_value` returns the switch value unchanged.
- R4: With `cmd_mode`=1 (sparse), the word at base holds the pair count n, and pair i has its key at base+1+2i and its offset at base+2+2i. Keys are compared in ascending i and the first equal key wins. The target is the offset address plus its contents, modulo 2^16.
- R5: On a sparse miss with n>0, `res_hit` is 0 and `res_addr` is base+2n+1.
- R6: A sparse table with n=0 misses with `res_addr`=base+1 after a single memory read.
- R7: `busy` rises in the cycle after a command is accepted and stays high through the `done` cycle. A command presented while `busy` is high is ignored.
- R8: `done` is a one-cycle pulse, issued while `busy` is high and together with valid `res_hit` and `res_addr`. `busy` is low in the following cycle.
- R9: `mem_rd` is asserted only while busy, and never in the `done` cycle. A dense hit takes 3 reads and a dense miss takes 2. A sparse lookup takes 1+n reads on a miss and i+3 reads on a hit at pair i.
- R10: While reset is asserted, `busy`, `done` and `mem_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request; accepted when not busy |
| cmd_mode | input | 1 | 0 = dense range table, 1 = sparse key table |
| cmd_base | input | 16 | Table base word address |
| cmd_value | input | 16 | Switch value |
| busy | output | 1 | Command in progress |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle completion pulse |
| res_hit | output | 1 | 1 = jump target, 0 = continuation address |
| res_addr | output | 16 | Target or continuation address |
| res_value | output | 16 | Switch value of the command |

## Verification
The bench builds the engine with the default width of 16. It backs the engine with a 1024-word memory that aliases the full address space. Because of this, a dense table placed at base 0xFFFE wraps its entries to address 0, and random 16-bit offsets wrap the target sum. The bench draws random values around the highest case, so borrow misses, count misses and every in-range entry all occur. Sparse keys are drawn from a narrow range, so duplicate keys test the first-match rule.

// File: rtl/case_dispatch_pkg.sv
`timescale 1ns/1ps
package case_dispatch_pkg;

    localparam logic MODE_DENSE  = 1'b0;
    localparam logic MODE_SPARSE = 1'b1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DNUM,
        ST_DCHK,
        ST_SINIT,
        ST_SKEY,
        ST_SCMP,
        ST_OFFRD,
        ST_TGT,
        ST_DONE
    } cd_state_e;

endpackage

// File: rtl/cd_dense_eval.sv
`timescale 1ns/1ps
// Dense-table range evaluation: distance from the highest case and in-range test.
module cd_dense_eval #(
    parameter int W = 16
) (
    input  logic [W-1:0] last_word,
    input  logic [W-1:0] sw_value,
    input  logic [W-1:0] count_word,
    input  logic [W-1:0] held_diff,
    input  logic         held_borrow,
    output logic [W-1:0] diff,
    output logic         borrow,
    output logic         in_range
);
    logic [W:0] wide;

    assign wide     = {1'b0, last_word} - {1'b0, sw_value};
    assign diff     = wide[W-1:0];
    assign borrow   = wide[W];
    // R2: no borrow and count strictly above the distance
    assign in_range = !held_borrow && (count_word > held_diff);
endmodule

// File: rtl/cd_addr_add.sv
`timescale 1ns/1ps
// Modulo-2^W address adder.
module cd_addr_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    assign sum = a + b;
endmodule

// File: rtl/case_dispatch.sv
`timescale 1ns/1ps
module case_dispatch
    import case_dispatch_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic         cmd_mode,
    input  logic [W-1:0] cmd_base,
    input  logic [W-1:0] cmd_value,
    output logic         busy,
    output logic         mem_rd,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic         done,
    output logic         res_hit,
    output logic [W-1:0] res_addr,
    output logic [W-1:0] res_value
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    cd_state_e    state_q, state_d;
    logic         mode_q;
    logic [W-1:0] base_q, value_q, diff_q, ptr_q, remain_q, off_addr_q, res_addr_q;
    logic         borrow_q, hit_q;

    logic [W-1:0] diff_w, base_plus2, dense_cont, tgt_sum, sparse_end;
    logic         borrow_w, in_range_w, key_match;

    assign base_plus2 = base_q + TWO;
    assign sparse_end = base_q + ONE + {mem_rdata[W-2:0], 1'b0};
    assign key_match  = (mem_rdata == value_q);

    cd_dense_eval #(.W(W)) u_eval (
        .last_word  (mem_rdata),
        .sw_value   (value_q),
        .count_word (mem_rdata),
        .held_diff  (diff_q),
        .held_borrow(borrow_q),
        .diff       (diff_w),
        .borrow     (borrow_w),
        .in_range   (in_range_w)
    );

    cd_addr_add #(.W(W)) u_cont_add (
        .a  (base_plus2),
        .b  (mem_rdata),
        .sum(dense_cont)
    );

    cd_addr_add #(.W(W)) u_tgt_add (
        .a  (off_addr_q),
        .b  (mem_rdata),
        .sum(tgt_sum)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = ST_HEAD;
            ST_HEAD:  state_d = (mode_q == MODE_DENSE) ? ST_DNUM : ST_SINIT;
            ST_DNUM:  state_d = ST_DCHK;
            ST_DCHK:  state_d = in_range_w ? ST_OFFRD : ST_DONE;
            ST_SINIT: state_d = (mem_rdata == '0) ? ST_DONE : ST_SKEY;
            ST_SKEY:  state_d = ST_SCMP;
            ST_SCMP: begin
                if (key_match)            state_d = ST_OFFRD;
                else if (remain_q == ONE) state_d = ST_DONE;
                else                      state_d = ST_SKEY;
            end
            ST_OFFRD: state_d = ST_TGT;
            ST_TGT:   state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_DENSE;
            base_q     <= '0;
            value_q    <= '0;
            diff_q     <= '0;
            borrow_q   <= 1'b0;
            ptr_q      <= '0;
            remain_q   <= '0;
            off_addr_q <= '0;
            res_addr_q <= '0;
            hit_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    mode_q  <= cmd_mode;
                    base_q  <= cmd_base;
                    value_q <= cmd_value;
                    hit_q   <= 1'b0;
                end
                ST_DNUM: begin
                    diff_q   <= diff_w;
                    borrow_q <= borrow_w;
                end
                ST_DCHK: begin
                    if (in_range_w) off_addr_q <= base_plus2 + diff_q;
                    else            res_addr_q <= dense_cont;
                end
                ST_SINIT: begin
                    ptr_q      <= base_q + ONE;
                    remain_q   <= mem_rdata;
                    res_addr_q <= sparse_end;
                end
                ST_SCMP: begin
                    if (key_match) begin
                        off_addr_q <= ptr_q + ONE;
                    end else begin
                        ptr_q    <= ptr_q + TWO;
                        remain_q <= remain_q - ONE;
                    end
                end
                ST_TGT: begin
                    res_addr_q <= tgt_sum;
                    hit_q      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_HEAD:  begin mem_rd = 1'b1; mem_addr = base_q;       end
            ST_DNUM:  begin mem_rd = 1'b1; mem_addr = base_q + ONE; end
            ST_SKEY:  begin mem_rd = 1'b1; mem_addr = ptr_q;        end
            ST_OFFRD: begin mem_rd = 1'b1; mem_addr = off_addr_q;   end
            ST_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign res_hit   = hit_q;
    assign res_addr  = res_addr_q;
    assign res_value = value_q;
endmodule

// File: rtl/cd_checker.sv
`timescale 1ns/1ps
module cd_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic mem_rd
);
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy);

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_read_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (busy && !done));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !mem_rd));
endmodule

bind case_dispatch cd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd)
);

// File: tb/case_dispatch_tb.sv
`timescale 1ns/1ps
module case_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_mode = 1'b0;
    logic [15:0] cmd_base = '0;
    logic [15:0] cmd_value = '0;
    logic        busy, mem_rd, done, res_hit;
    logic [15:0] mem_addr, res_addr, res_value;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem [0:1023];
    int          rd_cnt = 0;
    int          checks = 0;
    int          errs = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    case_dispatch #(.W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_base(cmd_base), .cmd_value(cmd_value), .busy(busy), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .res_hit(res_hit),
        .res_addr(res_addr), .res_value(res_value)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[9:0]];
            rd_cnt    <= rd_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errs++;
            $display("FAIL R8 watchdog: actual no completion expected done pulse");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    function automatic logic [15:0] rd(input logic [15:0] a);
        return mem[a[9:0]];
    endfunction

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        mem[a[9:0]] = d;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ref_calc(input logic mode, input logic [15:0] b, input logic [15:0] v,
                            output logic eh, output logic [15:0] ea, output int er);
        logic [15:0] last, num, diff, e, n, ka;
        if (!mode) begin
            last = rd(b);
            num  = rd(b + 16'd1);
            diff = last - v;
            if (v <= last && num > diff) begin
                e  = b + 16'd2 + diff;
                eh = 1'b1; ea = e + rd(e); er = 3;
            end else begin
                eh = 1'b0; ea = b + 16'd2 + num; er = 2;
            end
        end else begin
            n  = rd(b);
            eh = 1'b0; ea = b + 16'd1 + (n << 1); er = 1 + int'(n);
            for (int i = 0; i < int'(n); i++) begin
                ka = b + 16'd1 + 16'(2 * i);
                if (rd(ka) == v) begin
                    eh = 1'b1; ea = (ka + 16'd1) + rd(ka + 16'd1); er = i + 3;
                    break;
                end
            end
        end
    endtask

    task automatic run(input logic mode, input logic [15:0] b, input logic [15:0] v,
                       input bit poke, input string req);
        logic eh; logic [15:0] ea; int er; int r0;
        ref_calc(mode, b, v, eh, ea, er);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = mode; cmd_base = b; cmd_value = v;
        r0 = rd_cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            chk("R7", "busy after accept", 32'(busy), 32'd1);
            cmd_valid = 1'b1; cmd_mode = ~mode; cmd_base = b + 16'd40; cmd_value = ~v;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(req, "hit", 32'(res_hit), 32'(eh));
        chk(req, "addr", 32'(res_addr), 32'(ea));
        chk("R3", "value echo", 32'(res_value), 32'(v));
        chk("R9", "read count", 32'(rd_cnt - r0), 32'(er));
        @(negedge clk);
        chk("R8", "done pulse then idle", {30'd0, done, busy}, 32'd0);
    endtask

    task automatic build_dense(input logic [15:0] b, input logic [15:0] last,
                               input logic [15:0] num);
        wr(b, last);
        wr(b + 16'd1, num);
        for (int i = 0; i < int'(num); i++) wr(b + 16'd2 + 16'(i), 16'($urandom));
    endtask

    task automatic build_sparse(input logic [15:0] b, input int n, input int krange);
        wr(b, 16'(n));
        for (int i = 0; i < n; i++) begin
            wr(b + 16'd1 + 16'(2 * i), 16'($urandom % krange));
            wr(b + 16'd2 + 16'(2 * i), 16'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd20240));
        for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 7 + 3);

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", "busy/done/mem_rd in reset", {29'd0, busy, done, mem_rd}, 32'd0);
        rst_n = 1'b1;

        // Dense directed: highest case 50, five entries
        build_dense(16'd100, 16'd50, 16'd5);
        run(1'b0, 16'd100, 16'd50, 1'b0, "R1");      // first entry
        run(1'b0, 16'd100, 16'd46, 1'b0, "R1");      // last entry
        run(1'b0, 16'd100, 16'd45, 1'b0, "R2");      // distance equals count
        run(1'b0, 16'd100, 16'd51, 1'b0, "R2");      // above highest case
        run(1'b0, 16'd100, 16'hFFFF, 1'b0, "R3");
        build_dense(16'd140, 16'd9, 16'd0);
        run(1'b0, 16'd140, 16'd9, 1'b0, "R2");       // empty dense table
        // Wrap: entries cross address 0
        build_dense(16'hFFFE, 16'd10, 16'd3);
        run(1'b0, 16'hFFFE, 16'd9, 1'b1, "R1");

        // Sparse directed: keys 7,3,7,9
        build_sparse(16'd300, 4, 1);
        wr(16'd301, 16'd7); wr(16'd303, 16'd3); wr(16'd305, 16'd7); wr(16'd307, 16'd9);
        run(1'b1, 16'd300, 16'd7, 1'b0, "R4");       // first match wins
        run(1'b1, 16'd300, 16'd9, 1'b1, "R4");
        run(1'b1, 16'd300, 16'd5, 1'b0, "R5");
        wr(16'd400, 16'd0);
        run(1'b1, 16'd400, 16'd0, 1'b0, "R6");

        // Random dense
        for (int t = 0; t < 60; t++) begin
            logic [15:0] b, last, num, v;
            b    = 16'(100 + $urandom % 600);
            last = 16'($urandom);
            num  = 16'($urandom % 9);
            build_dense(b, last, num);
            if ($urandom % 4 == 0) v = last + 16'(1 + $urandom % 3);
            else                   v = last - 16'($urandom % 12);
            run(1'b0, b, v, (t % 10) == 0, "R2");
        end
        // Random sparse
        for (int t = 0; t < 60; t++) begin
            logic [15:0] b;
            int n;
            b = 16'(100 + $urandom % 600);
            n = $urandom % 7;
            build_sparse(b, n, 6);
            run(1'b1, b, 16'($urandom % 8), (t % 10) == 0, "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule